// File: doc/BRIEF.md
# Multi-Form Integer Multiply Unit

This block is the multiply stage of a processor execution pipeline. A caller puts two 32-bit operands and a mode on its inputs and pulses `start`. The unit multiplies them with an iterative shift-and-add loop. When the product is ready it pulses `done` for one cycle, together with the result words and the condition flags.

The operands can be treated as two's-complement or as unsigned values, and the product has the same signedness. There are three result forms:

- **Word:** multiplies the low halves of the operands into a full 32-bit product.
- **Long:** multiplies full 32-bit operands and keeps only the low 32 bits. It reports overflow when the discarded bits carry information.
- **Quad:** multiplies full 32-bit operands and delivers the whole 64-bit product as a high word and a low word.

The flags follow the usual architectural rules. The carry flag is always cleared, and the extend flag is marked as left alone.

Top module: `mul_unit`

## Requirements
- R1: After reset, `busy`, `done`, `res_hi`, `res_lo`, `flag_n`, `flag_z` and `flag_v` are all 0.
- R2: Word form (`long_op`=0), signed mode (`signed_mode`=1): the low 16 bits of each operand are sign-extended and multiplied. The 32-bit product appears on `res_lo`.
- R3: Word form, unsigned mode (`signed_mode`=0): the low 16 bits of each operand are zero-extended. The upper operand bits have no effect on the product.
- R4: Long form (`long_op`=1, `wide_res`=0): `res_lo` holds the low 32 bits of the 32x32 product. `res_hi` reads 0 in the word and long forms.
- R5: Long form, signed mode: `flag_v` is 1 exactly when the signed product lies outside the 32-bit two's-complement range.
- R6: Long form, unsigned mode: `flag_v` is 1 exactly when the product is 2^32 or larger.
- R7: Quad form (`long_op`=1, `wide_res`=1): the 64-bit product is split across the outputs, with bits 63..32 on `res_hi` and bits 31..0 on `res_lo`.
- R8: `flag_n` equals bit 31 of `res_lo` in the word and long forms, and bit 31 of `res_hi` in the quad form.
- R9: `flag_z` is 1 only when the whole delivered result is zero. In the quad form that means all 64 bits.
- R10: `flag_v` is 0 in the word and quad forms. `flag_c` is always 0, and `keep_x` is always 1.
- R11: `done` is high for exactly one cycle. It appears 17 clock edges after the edge that samples `start` in the word form, and 33 edges after it in the long and quad forms. `busy` is high from the edge after `start` until `done` rises.
- R12: A `start` pulse while `busy` is high is ignored. The running operation completes with its own operands and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when not busy |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| signed_mode | input | 1 | 1 = two's-complement, 0 = unsigned |
| long_op | input | 1 | 1 = 32-bit operands, 0 = 16-bit word form |
| wide_res | input | 1 | With long_op: 1 = 64-bit result, 0 = truncated 32-bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid strobe |
| res_hi | output | 32 | Upper result word (quad form only) |
| res_lo | output | 32 | Lower result word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always 0 |
| keep_x | output | 1 | Extend flag to be left unchanged, always 1 |

## Verification
The bench targets three kinds of corner case:

- **Signed extremes:** products such as -32768 squared and 0x80000000 times 0x7FFFFFFF. A unit that negated magnitudes in too narrow a width would return a wrong sign or a wrong high word.
- **Truncation boundary:** products of exactly -2^31 (no overflow) and of 2^32 (overflow with a zero low word). A wrong overflow test would set V on a representable value, or clear Z while V is set.
- **Whole-width zero test:** a quad product whose low word is zero but whose high word is not. A Z flag that tested only the low word would report zero here.

A start pulse inserted mid-operation exposes a unit that restarts, or one that latches the new mode.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;

  typedef enum logic [1:0] {
    FORM_WORD = 2'd0,
    FORM_LONG = 2'd1,
    FORM_QUAD = 2'd2
  } form_e;
endpackage

// File: rtl/mul_prep.sv
module mul_prep #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          sgn,
  input  logic          is_long,
  output logic [DW-1:0] mag_a,
  output logic [DW-1:0] mag_b,
  output logic          neg
);
  localparam int HW = DW / 2;

  // Widen a word-form operand to full width, by sign or zero extension.
  function automatic logic [DW-1:0] widen(input logic [DW-1:0] v, input logic s, input logic lng);
    if (lng) return v;
    return s ? {{HW{v[HW-1]}}, v[HW-1:0]} : {{HW{1'b0}}, v[HW-1:0]};
  endfunction

  // Unsigned magnitude; the most negative value maps onto its own bit pattern.
  function automatic logic [DW-1:0] magnitude(input logic [DW-1:0] v, input logic s);
    return (s && v[DW-1]) ? (~v + 1'b1) : v;
  endfunction

  logic [DW-1:0] ext_a, ext_b;

  always_comb begin
    ext_a = widen(a_in, sgn, is_long);
    ext_b = widen(b_in, sgn, is_long);
    mag_a = magnitude(ext_a, sgn);
    mag_b = magnitude(ext_b, sgn);
    neg   = sgn & (ext_a[DW-1] ^ ext_b[DW-1]);
  end
endmodule

// File: rtl/mul_core.sv
module mul_core
  import mul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   mag_a,
  input  logic [DW-1:0]   mag_b,
  input  logic            neg_in,
  input  logic            half_len,
  output logic            busy,
  output logic            fin,
  output logic [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;
  localparam int HW = DW / 2;
  localparam int CW = $clog2(DW);

  mul_state_e    state;
  logic [PW-1:0] mcand, acc;
  logic [DW-1:0] mplier;
  logic [CW-1:0] cnt;
  logic          neg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      mcand  <= '0;
      acc    <= '0;
      mplier <= '0;
      cnt    <= '0;
      neg_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          mcand  <= PW'(mag_a);
          mplier <= mag_b;
          acc    <= '0;
          neg_q  <= neg_in;
          cnt    <= half_len ? CW'(HW - 1) : CW'(DW - 1);
          state  <= ST_RUN;
        end
        ST_RUN: begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          if (cnt == '0) state <= ST_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign fin  = (state == ST_FIN);
  assign prod = neg_q ? (~acc + 1'b1) : acc;

  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !fin);  // R11
  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !busy); // R11
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cnt != '0) |=> (state == ST_RUN));                              // R12
endmodule

// File: rtl/mul_flags.sv
module mul_flags
  import mul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2*DW-1:0] prod,
  input  form_e           form,
  input  logic            sgn,
  output logic [DW-1:0]   hi,
  output logic [DW-1:0]   lo,
  output logic            n,
  output logic            z,
  output logic            v
);
  // True when the full product does not fit in the low DW bits.
  function automatic logic trunc_ovf(input logic [2*DW-1:0] p, input logic s);
    if (s) return p[2*DW-1:DW] != {DW{p[DW-1]}};
    return p[2*DW-1:DW] != '0;
  endfunction

  always_comb begin
    lo = prod[DW-1:0];
    if (form == FORM_QUAD) begin
      hi = prod[2*DW-1:DW];
      n  = prod[2*DW-1];
      z  = (prod == '0);
      v  = 1'b0;
    end else begin
      hi = '0;
      n  = prod[DW-1];
      z  = (prod[DW-1:0] == '0);
      v  = (form == FORM_LONG) ? trunc_ovf(prod, sgn) : 1'b0;
    end
  end
endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          signed_mode,
  input  logic          long_op,
  input  logic          wide_res,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res_hi,
  output logic [DW-1:0] res_lo,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          keep_x
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] mag_a, mag_b;
  logic          neg, fin, accept;
  logic [PW-1:0] prod;
  form_e         form_q;
  logic          sgn_q;
  logic [DW-1:0] f_hi, f_lo;
  logic          f_n, f_z, f_v;

  assign accept = start & ~busy;

  mul_prep #(.DW(DW)) u_prep (
    .a_in(op_a), .b_in(op_b), .sgn(signed_mode), .is_long(long_op),
    .mag_a(mag_a), .mag_b(mag_b), .neg(neg)
  );

  mul_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .mag_a(mag_a), .mag_b(mag_b),
    .neg_in(neg), .half_len(~long_op), .busy(busy), .fin(fin), .prod(prod)
  );

  mul_flags #(.DW(DW)) u_flags (
    .prod(prod), .form(form_q), .sgn(sgn_q),
    .hi(f_hi), .lo(f_lo), .n(f_n), .z(f_z), .v(f_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      form_q <= FORM_WORD;
      sgn_q  <= 1'b0;
      done   <= 1'b0;
      res_hi <= '0;
      res_lo <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        sgn_q  <= signed_mode;
        form_q <= !long_op ? FORM_WORD : (wide_res ? FORM_QUAD : FORM_LONG);
      end
      if (fin) begin
        res_hi <= f_hi;
        res_lo <= f_lo;
        flag_n <= f_n;
        flag_z <= f_z;
        flag_v <= f_v;
      end
    end
  end

  assign flag_c = 1'b0;
  assign keep_x = 1'b1;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && form_q != FORM_LONG) |-> !flag_v);                                          // R10
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && form_q != FORM_QUAD) |-> (res_hi == '0));                                   // R4
  AST_N_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_n == ((form_q == FORM_QUAD) ? res_hi[DW-1] : res_lo[DW-1])));         // R8
  AST_Z_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == ({res_hi, res_lo} == '0)));                                      // R9
endmodule

// File: tb/tb_mul_unit.sv
`timescale 1ns/1ps
module tb_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        signed_mode = 1'b0, long_op = 1'b0, wide_res = 1'b0;
  logic        busy, done, flag_n, flag_z, flag_v, flag_c, keep_x;
  logic [31:0] res_hi, res_lo;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mul_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .signed_mode(signed_mode), .long_op(long_op), .wide_res(wide_res),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .keep_x(keep_x)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  // Reference model in plain integer arithmetic.
  task automatic model(input logic [31:0] a, input logic [31:0] b, input bit sgn, input bit lng,
                       input bit wide, output logic [31:0] ehi, output logic [31:0] elo,
                       output bit en, output bit ez, output bit ev);
    longint sa, sb;
    logic [63:0] p;
    if (!lng) begin
      sa = sgn ? longint'($signed(a[15:0])) : longint'(a[15:0]);
      sb = sgn ? longint'($signed(b[15:0])) : longint'(b[15:0]);
    end else begin
      sa = sgn ? longint'($signed(a)) : longint'({32'b0, a});
      sb = sgn ? longint'($signed(b)) : longint'({32'b0, b});
    end
    p = 64'(sa * sb);
    elo = p[31:0];
    if (lng && wide) begin
      ehi = p[63:32]; en = p[63]; ez = (p == 0); ev = 0;
    end else begin
      ehi = 0; en = elo[31]; ez = (elo == 0);
      if (!lng) ev = 0;
      else if (sgn) ev = (sa * sb) != longint'($signed(p[31:0]));
      else ev = p > 64'hFFFF_FFFF;
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sgn, input bit lng,
                        input bit wide, input string rtag, input bit poke);
    logic [31:0] ehi, elo;
    bit en, ez, ev, tim_ok;
    int lat;
    model(a, b, sgn, lng, wide, ehi, elo, en, ez, ev);
    lat = lng ? 33 : 17;
    tim_ok = 1;
    @(negedge clk);
    op_a = a; op_b = b; signed_mode = sgn; long_op = lng; wide_res = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: a second start mid-run with different operands and mode
      fork
        begin
          repeat (4) @(negedge clk);
          op_a = ~a; op_b = 32'h0000_0007; signed_mode = ~sgn; long_op = ~lng; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      join_none
    end
    for (int k = 1; k <= lat; k++) begin
      @(posedge clk); #1;
      if (k < lat && (done || !busy)) tim_ok = 0;
      if (k == lat && (!done || busy)) tim_ok = 0;
    end
    chk(tim_ok, poke ? "R12 timing" : "R11 timing", {63'b0, done}, 64'd1);
    chk(res_lo == elo, rtag, {32'b0, res_lo}, {32'b0, elo});
    chk(res_hi == ehi, (lng && wide) ? "R7" : "R4", {32'b0, res_hi}, {32'b0, ehi});
    chk(flag_n == en, "R8", {63'b0, flag_n}, {63'b0, en});
    chk(flag_z == ez, "R9", {63'b0, flag_z}, {63'b0, ez});
    chk(flag_v == ev, (lng && !wide) ? (sgn ? "R5" : "R6") : "R10", {63'b0, flag_v}, {63'b0, ev});
    chk(flag_c == 1'b0 && keep_x == 1'b1, "R10", {62'b0, flag_c, keep_x}, 64'd1);
    @(posedge clk); #1;
    chk(!done, "R11 pulse", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && res_hi == 0 && res_lo == 0 && !flag_n && !flag_z && !flag_v,
        "R1", {busy, done, flag_n, flag_z, flag_v, res_lo}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // word, signed
    run_op(32'hABCD_FFFE, 32'h1234_0003, 1, 0, 0, "R2", 0);
    run_op(32'h0000_8000, 32'hFFFF_8000, 1, 0, 0, "R2", 0);
    // word, unsigned: upper bits must not matter
    run_op(32'hDEAD_FFFF, 32'hBEEF_FFFF, 0, 0, 0, "R3", 0);
    run_op(32'h5555_0000, 32'h0000_1234, 0, 0, 0, "R3", 0);
    // long, truncated
    run_op(32'd12345, 32'd678, 0, 1, 0, "R4", 0);
    run_op(32'hFFFF_FFF9, 32'd9, 1, 1, 0, "R4", 0);
    run_op(32'h0001_0000, 32'h0001_0000, 1, 1, 0, "R5", 0);
    run_op(32'h8000_0000, 32'd1, 1, 1, 0, "R5", 0);
    run_op(32'hFFFF_0000, 32'h0000_8000, 1, 1, 0, "R5", 0);
    run_op(32'h8000_0000, 32'd2, 0, 1, 0, "R6", 0);
    run_op(32'hFFFF_FFFF, 32'd1, 0, 1, 0, "R6", 0);
    // quad
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, "R7", 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 1, "R7", 0);
    run_op(32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 1, "R7", 0);
    run_op(32'h0001_0000, 32'h0001_0000, 0, 1, 1, "R9", 0);
    run_op(32'h0000_0000, 32'h1234_5678, 1, 1, 1, "R9", 0);
    // start while busy is ignored
    run_op(32'hFFFF_FFFD, 32'd11, 1, 1, 0, "R12", 1);
    run_op(32'h0000_7FFF, 32'h0000_FFFF, 1, 0, 0, "R12", 1);
    run_op(32'd3, 32'd5, 0, 0, 0, "R2", 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule